// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the serial side of a single-channel telephony PCM codec. A transmit frame sync opens a time slot in which one compressed sample, taken from a parallel register that faces the codec core, is shifted out MSB first on the rising edges of the master clock. During that slot an active-low strobe is driven so that an external 3-state buffer can be enabled. A receive frame sync opens a second slot in which one sample is shifted in MSB first on the falling edges of the same clock. The block then presents the sample as a parallel byte together with a one-period valid pulse.

Each direction watches its own frame sync. A frame sync that stays low for a fixed time (300 ms by default) puts that direction into standby. A three-level clock-select input tells the block which of three master-clock rates is in use, so the timeout is always counted in the right number of cycles. Two gain-select bits are passed to the analog side, and one of their codes means power-down, which stops both slots. A law-select input is passed through as a registered mode flag for the companding logic.

Top module: `pcm_slot_port`

## Requirements
- R1: On the rising clock edge that first samples `fsx_i` high after it was low, and with power-down not in effect, the block captures `tx_sample_i`. `pcm_out_o` then presents that byte MSB first, one bit per rising edge, for eight rising edges. Later changes of `tx_sample_i` do not affect the byte in flight.
- R2: `tsx_n_o` is low and `pcm_oe_o` is high for exactly the eight clock periods of the transmit slot. Outside the slot, `tsx_n_o` is high and both `pcm_out_o` and `pcm_oe_o` are low.
- R3: On the falling edge that first samples `fsr_i` high after it was low, and on the seven falling edges after it, `pcm_in_i` is captured MSB first. The edge that sees the rise takes bit 7.
- R4: `rx_valid_o` rises on the falling edge that captures the eighth bit and stays high for exactly one clock period. `rx_sample_o` is loaded with the byte on that same edge and holds it until the next byte completes. Both outputs are 0 after reset.
- R5: `tx_standby_o` rises on the rising edge that completes `TIMEOUT_MS*F` consecutive low samples of `fsx_i`. F is 1544 for `clk_sel_i`=2'b00, 1536 for 2'b01, and 2048 for 2'b10 or 2'b11. The selection is registered one rising edge before it is used.
- R6: `rx_standby_o` follows the same rule on falling edges for `fsr_i`. It is independent of the transmit direction: a frame on one direction does not clear the other direction's standby.
- R7: A rising frame sync clears that direction's standby on the edge that detects it, and restarts its slot at bit zero.
- R8: `gain_sel_i`=2'b00 means power-down. It is registered to `pwrdn_o` on the next rising edge. While it is in effect, no transmit slot starts, `tsx_n_o` stays high, `rx_valid_o` stays low and `rx_sample_o` holds its value.
- R9: `alaw_o` and `gain_o` take the values of `law_sel_i` and `gain_sel_i` one rising edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; transmit on rising, receive on falling edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Master-clock rate code (00: 1.544, 01: 1.536, 1x: 2.048 MHz) |
| law_sel_i | input | 1 | Companding law choice (1 = A-law, 0 = µ-law) |
| gain_sel_i | input | 2 | Gain code for both directions; 00 commands power-down |
| fsx_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync |
| tx_sample_i | input | W | Parallel sample to transmit |
| pcm_out_o | output | 1 | Serial transmit data |
| pcm_oe_o | output | 1 | High while serial transmit data is valid |
| tsx_n_o | output | 1 | Active-low transmit slot strobe |
| pcm_in_i | input | 1 | Serial receive data |
| rx_sample_o | output | W | Last complete received sample |
| rx_valid_o | output | 1 | One-period pulse when a received sample completes |
| tx_standby_o | output | 1 | Transmit direction in standby |
| rx_standby_o | output | 1 | Receive direction in standby |
| alaw_o | output | 1 | Registered law flag |
| gain_o | output | 2 | Registered gain code |
| pwrdn_o | output | 1 | Registered power-down flag |

## Verification
The bench builds the block with `W`=8 and `TIMEOUT_MS`=1. This shrinks the standby windows to 1544, 1536 and 2048 master-clock cycles, so the exact edge at which standby rises can be checked for every clock-select code, in both directions, within a short run. The three rate parameters keep their defaults. As a result, the mapping from select code to terminal count is checked against the very values a real 300 ms build scales.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        CLKSEL_1544  = 2'b00,
        CLKSEL_1536  = 2'b01,
        CLKSEL_2048  = 2'b10,
        CLKSEL_2048B = 2'b11
    } clk_rate_e;

    localparam logic [1:0] GAIN_SEL_PWRDN = 2'b00;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pcm_fs_watch.sv
// Frame-sync edge detector and low-time standby timer for one direction.
module pcm_fs_watch #(
    parameter int unsigned CW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fs_i,
    input  logic [CW-1:0] term_i,
    output logic          fs_rise_o,
    output logic          standby_o
);

    typedef struct packed {
        logic          fs;
        logic [CW-1:0] cnt;
        logic          standby;
    } watch_t;

    watch_t q, d;

    always_comb begin
        d    = q;
        d.fs = fs_i;
        if (fs_i) begin
            d.cnt     = '0;
            d.standby = 1'b0;
        end else begin
            d.cnt     = (q.cnt >= term_i) ? q.cnt : q.cnt + CW'(1);
            d.standby = q.standby | (q.cnt >= term_i - CW'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fs_rise_o = fs_i & ~q.fs;
    assign standby_o = q.standby;

endmodule

// File: rtl/pcm_tx_slot.sv
// Transmit slot: parallel load on frame-sync rise, MSB-first shift-out.
module pcm_tx_slot #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fs_i,
    input  logic [CW-1:0] term_i,
    input  logic          pwrdn_i,
    input  logic [W-1:0]  sample_i,
    output logic          sdo_o,
    output logic          oe_o,
    output logic          strobe_n_o,
    output logic          standby_o
);

    localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          active;
        logic [BW-1:0] cnt;
        logic [W-1:0]  sr;
    } tx_t;

    tx_t  q, d;
    logic fs_rise;

    pcm_fs_watch #(.CW(CW)) watch_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fs_i      (fs_i),
        .term_i    (term_i),
        .fs_rise_o (fs_rise),
        .standby_o (standby_o)
    );

    always_comb begin
        d = q;
        if (pwrdn_i) begin
            d.active = 1'b0;
        end else if (fs_rise) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.sr     = sample_i;
        end else if (q.active) begin
            if (q.cnt == BW'(W - 1)) begin
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt + BW'(1);
                d.sr  = q.sr << 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo_o      = q.active & q.sr[W-1];
    assign oe_o       = q.active;
    assign strobe_n_o = ~q.active;

endmodule

// File: rtl/pcm_rx_slot.sv
// Receive slot: MSB-first shift-in, parallel hold register and valid pulse.
// Clocked by the inverted master clock, so every register moves on falling edges.
module pcm_rx_slot #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fs_i,
    input  logic [CW-1:0] term_i,
    input  logic          pwrdn_i,
    input  logic          sdi_i,
    output logic [W-1:0]  data_o,
    output logic          valid_o,
    output logic          standby_o
);

    localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          active;
        logic [BW-1:0] cnt;
        logic [W-1:0]  sr;
        logic [W-1:0]  data;
        logic          valid;
    } rx_t;

    rx_t        q, d;
    logic       fs_rise;
    logic [W-1:0] sr_next;

    pcm_fs_watch #(.CW(CW)) watch_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fs_i      (fs_i),
        .term_i    (term_i),
        .fs_rise_o (fs_rise),
        .standby_o (standby_o)
    );

    assign sr_next = {q.sr[W-2:0], sdi_i};

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (pwrdn_i) begin
            d.active = 1'b0;
        end else if (fs_rise) begin
            d.active = 1'b1;
            d.cnt    = BW'(1);
            d.sr     = {{(W-1){1'b0}}, sdi_i};
        end else if (q.active) begin
            d.sr = sr_next;
            if (q.cnt == BW'(W - 1)) begin
                d.active = 1'b0;
                d.data   = sr_next;
                d.valid  = 1'b1;
            end else begin
                d.cnt = q.cnt + BW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned W            = 8,
    parameter int unsigned TIMEOUT_MS   = 300,
    parameter int unsigned KHZ_RATE_HI  = 2048,
    parameter int unsigned KHZ_RATE_MID = 1544,
    parameter int unsigned KHZ_RATE_LO  = 1536
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   clk_sel_i,
    input  logic         law_sel_i,
    input  logic [1:0]   gain_sel_i,
    input  logic         fsx_i,
    input  logic         fsr_i,
    input  logic [W-1:0] tx_sample_i,
    output logic         pcm_out_o,
    output logic         pcm_oe_o,
    output logic         tsx_n_o,
    input  logic         pcm_in_i,
    output logic [W-1:0] rx_sample_o,
    output logic         rx_valid_o,
    output logic         tx_standby_o,
    output logic         rx_standby_o,
    output logic         alaw_o,
    output logic [1:0]   gain_o,
    output logic         pwrdn_o
);

    localparam int unsigned TERM_HI  = TIMEOUT_MS * KHZ_RATE_HI;
    localparam int unsigned TERM_MID = TIMEOUT_MS * KHZ_RATE_MID;
    localparam int unsigned TERM_LO  = TIMEOUT_MS * KHZ_RATE_LO;
    localparam int unsigned TERM_MAX = max3(TERM_HI, TERM_MID, TERM_LO);
    localparam int unsigned CW       = $clog2(TERM_MAX + 1);

    typedef struct packed {
        logic          law;
        logic [1:0]    gain;
        logic          pwrdn;
        logic [CW-1:0] term;
    } mode_t;

    mode_t q, d;
    logic  rx_clk;

    always_comb begin
        d       = q;
        d.law   = law_sel_i;
        d.gain  = gain_sel_i;
        d.pwrdn = (gain_sel_i == GAIN_SEL_PWRDN);
        case (clk_rate_e'(clk_sel_i))
            CLKSEL_1544: d.term = CW'(TERM_MID);
            CLKSEL_1536: d.term = CW'(TERM_LO);
            default:     d.term = CW'(TERM_HI);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{law: 1'b0, gain: 2'b11, pwrdn: 1'b0, term: CW'(TERM_HI)};
        end else begin
            q <= d;
        end
    end

    assign rx_clk = ~clk_i;

    pcm_tx_slot #(.W(W), .CW(CW)) tx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fs_i       (fsx_i),
        .term_i     (q.term),
        .pwrdn_i    (q.pwrdn),
        .sample_i   (tx_sample_i),
        .sdo_o      (pcm_out_o),
        .oe_o       (pcm_oe_o),
        .strobe_n_o (tsx_n_o),
        .standby_o  (tx_standby_o)
    );

    pcm_rx_slot #(.W(W), .CW(CW)) rx_i (
        .clk_i     (rx_clk),
        .rst_ni    (rst_ni),
        .fs_i      (fsr_i),
        .term_i    (q.term),
        .pwrdn_i   (q.pwrdn),
        .sdi_i     (pcm_in_i),
        .data_o    (rx_sample_o),
        .valid_o   (rx_valid_o),
        .standby_o (rx_standby_o)
    );

    assign alaw_o  = q.law;
    assign gain_o  = q.gain;
    assign pwrdn_o = q.pwrdn;

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         law_sel_i,
    input logic         fsx_i,
    input logic         fsr_i,
    input logic         tsx_n_o,
    input logic [W-1:0] rx_sample_o,
    input logic         rx_valid_o,
    input logic         tx_standby_o,
    input logic         rx_standby_o,
    input logic         alaw_o,
    input logic         pwrdn_o
);

    localparam int unsigned RW = $clog2(W + 2) + 1;

    logic [RW-1:0] low_run_q;
    logic          past_ok_q;
    logic          past_ok_n_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run_q <= '0;
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
            if (tsx_n_o) begin
                low_run_q <= '0;
            end else if (low_run_q != RW'(W + 1)) begin
                low_run_q <= low_run_q + RW'(1);
            end
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            past_ok_n_q <= 1'b0;
        end else begin
            past_ok_n_q <= 1'b1;
        end
    end

    // R1: a frame-sync rise outside power-down opens the slot on the next cycle
    assert_slot_opens_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(fsx_i) && !pwrdn_o) |=> !tsx_n_o);

    // R2: the strobe never stays low longer than one sample
    assert_strobe_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_run_q <= RW'(W));

    // R4: valid lasts a single clock period
    assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    // R5: transmit standby only follows a low frame sync
    assert_tx_standby_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && tx_standby_o) |-> !$past(fsx_i));

    // R6: receive standby only follows a low frame sync, on falling edges
    assert_rx_standby_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (past_ok_n_q && rx_standby_o) |-> !$past(fsr_i));

    // R8: no slot opens and no byte is delivered in power-down
    assert_pwrdn_no_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwrdn_o && tsx_n_o) |=> tsx_n_o);

    assert_pwrdn_rx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_o |-> (!rx_valid_o && $stable(rx_sample_o)));

    // R9: law flag is the law select one edge later
    assert_law_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok_q |-> (alaw_o == $past(law_sel_i)));

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.W(W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .law_sel_i    (law_sel_i),
    .fsx_i        (fsx_i),
    .fsr_i        (fsr_i),
    .tsx_n_o      (tsx_n_o),
    .rx_sample_o  (rx_sample_o),
    .rx_valid_o   (rx_valid_o),
    .tx_standby_o (tx_standby_o),
    .rx_standby_o (rx_standby_o),
    .alaw_o       (alaw_o),
    .pwrdn_o      (pwrdn_o)
);

// File: tb/pcm_slot_port_tb_top.sv
module pcm_slot_port_tb_top;

    localparam int W   = 8;
    localparam int TMS = 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   clk_sel;
    logic         law_sel;
    logic [1:0]   gain_sel;
    logic         fsx, fsr;
    logic [W-1:0] tx_sample;
    logic         pcm_out, pcm_oe, tsx_n;
    logic         pcm_in;
    logic [W-1:0] rx_sample;
    logic         rx_valid, tx_standby, rx_standby;
    logic         alaw, pwrdn;
    logic [1:0]   gain;

    always #5 clk = ~clk;

    pcm_slot_port #(.W(W), .TIMEOUT_MS(TMS)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .clk_sel_i    (clk_sel),
        .law_sel_i    (law_sel),
        .gain_sel_i   (gain_sel),
        .fsx_i        (fsx),
        .fsr_i        (fsr),
        .tx_sample_i  (tx_sample),
        .pcm_out_o    (pcm_out),
        .pcm_oe_o     (pcm_oe),
        .tsx_n_o      (tsx_n),
        .pcm_in_i     (pcm_in),
        .rx_sample_o  (rx_sample),
        .rx_valid_o   (rx_valid),
        .tx_standby_o (tx_standby),
        .rx_standby_o (rx_standby),
        .alaw_o       (alaw),
        .gain_o       (gain),
        .pwrdn_o      (pwrdn)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [W-1:0] tx_q[$];
    logic [W-1:0] rx_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Transmit monitor: assembles bits during the strobe, compares with the queue
    logic [W-1:0] tx_bits;
    logic [W-1:0] tx_exp;
    int           tx_n      = 0;
    int           idle_bad  = 0;
    int           strobe_lo = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!tsx_n) begin
                strobe_lo++;
                if (!pcm_oe) idle_bad++;
                tx_bits = {tx_bits[W-2:0], pcm_out};
                tx_n++;
                if (tx_n == W) begin
                    tx_n = 0;
                    if (tx_q.size() == 0) begin
                        check(1'b0, "R2 unexpected slot", tx_bits, 0);
                    end else begin
                        tx_exp = tx_q.pop_front();
                        check(tx_bits == tx_exp, "R1 tx byte", tx_bits, tx_exp);
                    end
                end
            end else begin
                if (pcm_out || pcm_oe) idle_bad++;
                if (tx_n != 0) begin
                    check(1'b0, "R2 strobe length", tx_n, W);
                    tx_n = 0;
                end
            end
        end
    end

    // Receive monitor: each valid pulse pops one expected byte
    logic [W-1:0] rx_exp;
    always @(posedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_q.size() == 0) begin
                check(1'b0, "R4 unexpected valid", rx_sample, 0);
            end else begin
                rx_exp = rx_q.pop_front();
                check(rx_sample == rx_exp, "R3 rx byte", rx_sample, rx_exp);
            end
        end
    end

    task automatic send_tx(input logic [W-1:0] b, input bit push);
        @(negedge clk);
        tx_sample = b;
        fsx       = 1'b1;
        if (push) tx_q.push_back(b);
        @(negedge clk);
        tx_sample = ~b;
        @(negedge clk);
        fsx = 1'b0;
    endtask

    task automatic send_rx(input logic [W-1:0] b, input bit push);
        if (push) rx_q.push_back(b);
        @(posedge clk); #1;
        fsr    = 1'b1;
        pcm_in = b[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            @(posedge clk); #1;
            pcm_in = b[i];
        end
        @(posedge clk); #1;
        fsr    = 1'b0;
        pcm_in = 1'b0;
    endtask

    task automatic tx_timeout(input logic [1:0] sel, input int f, input logic [W-1:0] b);
        @(negedge clk);
        clk_sel = sel;
        send_tx(b, 1'b1);
        check(tx_standby == 1'b0, "R7 tx standby cleared", tx_standby, 0);
        repeat (f - 1) @(posedge clk);
        #1;
        check(tx_standby == 1'b0, "R5 tx standby early", tx_standby, 0);
        @(posedge clk);
        #1;
        check(tx_standby == 1'b1, "R5 tx standby on time", tx_standby, 1);
    endtask

    task automatic rx_timeout(input int f, input logic [W-1:0] b);
        send_rx(b, 1'b1);
        check(rx_standby == 1'b0, "R7 rx standby cleared", rx_standby, 0);
        check(tx_standby == 1'b1, "R6 tx standby kept", tx_standby, 1);
        repeat (f - 1) @(negedge clk);
        #1;
        check(rx_standby == 1'b0, "R6 rx standby early", rx_standby, 0);
        @(negedge clk);
        #1;
        check(rx_standby == 1'b1, "R6 rx standby on time", rx_standby, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        int           lo_before;

        rst_n     = 1'b0;
        clk_sel   = 2'b10;
        law_sel   = 1'b0;
        gain_sel  = 2'b01;
        fsx       = 1'b0;
        fsr       = 1'b0;
        tx_sample = '0;
        pcm_in    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tsx_n == 1'b1, "R2 reset strobe", tsx_n, 1);
        check(pcm_oe == 1'b0, "R2 reset oe", pcm_oe, 0);
        check(pcm_out == 1'b0, "R2 reset data", pcm_out, 0);
        check(rx_valid == 1'b0, "R4 reset valid", rx_valid, 0);
        check(rx_sample == '0, "R4 reset sample", rx_sample, 0);

        // R1 R2: several transmit patterns
        foreach (tx_pat[i]) begin
            send_tx(tx_pat[i], 1'b1);
            repeat (W + 2) @(negedge clk);
        end

        // R3 R4: several receive patterns
        foreach (rx_pat[i]) begin
            send_rx(rx_pat[i], 1'b1);
            repeat (3) @(posedge clk);
        end
        repeat (20) @(posedge clk);
        #1;
        check(rx_sample == 8'hC3, "R4 sample held", rx_sample, 8'hC3);

        // Both directions in flight together
        fork
            send_tx(8'h96, 1'b1);
            send_rx(8'h69, 1'b1);
        join
        repeat (W + 4) @(negedge clk);

        // R9: mode pass-through
        @(negedge clk);
        law_sel  = 1'b1;
        gain_sel = 2'b10;
        @(posedge clk);
        #1;
        check(alaw == 1'b1, "R9 law flag", alaw, 1);
        check(gain == 2'b10, "R9 gain code", gain, 2'b10);
        check(pwrdn == 1'b0, "R8 no power-down", pwrdn, 0);
        @(negedge clk);
        law_sel = 1'b0;
        @(posedge clk);
        #1;
        check(alaw == 1'b0, "R9 law flag low", alaw, 0);

        // R5 R7: standby timing for each clock-select code
        tx_timeout(2'b00, 1544 * TMS, 8'h11);
        tx_timeout(2'b01, 1536 * TMS, 8'h22);
        tx_timeout(2'b10, 2048 * TMS, 8'h44);

        // R6 R7: receive standby, independent of transmit
        rx_timeout(2048 * TMS, 8'h7E);
        send_tx(8'hE7, 1'b1);
        check(tx_standby == 1'b0, "R7 tx standby cleared again", tx_standby, 0);
        check(rx_standby == 1'b1, "R6 rx standby kept", rx_standby, 1);
        repeat (W + 2) @(negedge clk);
        tx_timeout(2'b11, 2048 * TMS, 8'h88);

        // R8: power-down blocks both slots and holds the received byte
        @(negedge clk);
        gain_sel = 2'b00;
        @(posedge clk);
        #1;
        check(pwrdn == 1'b1, "R8 power-down flag", pwrdn, 1);
        held      = rx_sample;
        lo_before = strobe_lo;
        send_tx(8'hF0, 1'b0);
        send_rx(8'h0F, 1'b0);
        repeat (W + 2) @(negedge clk);
        check(strobe_lo == lo_before, "R8 strobe suppressed", strobe_lo - lo_before, 0);
        check(rx_sample == held, "R8 rx sample held", rx_sample, held);
        @(negedge clk);
        gain_sel = 2'b01;
        @(posedge clk);
        #1;
        check(pwrdn == 1'b0, "R8 power-down released", pwrdn, 0);
        send_tx(8'h5C, 1'b1);
        repeat (W + 2) @(negedge clk);
        send_rx(8'hA3, 1'b1);

        repeat (20) @(negedge clk);
        check(tx_q.size() == 0, "R1 all tx bytes seen", tx_q.size(), 0);
        check(rx_q.size() == 0, "R3 all rx bytes seen", rx_q.size(), 0);
        check(idle_bad == 0, "R2 line idle outside slot", idle_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    logic [W-1:0] tx_pat[5] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};
    logic [W-1:0] rx_pat[4] = '{8'h5A, 8'hFF, 8'h00, 8'hC3};

endmodule